// File: doc/BRIEF.md
# Store-Coalescing Data Access Port

This block sits between a simple execution core and a shared cache. The core sends one load or store request at a time. Ordinary stores go into a small buffer and are drained to the cache through a dedicated write port. Loads go to the cache through a separate read port. A store to a word that already has a buffered entry is folded into that entry, lane by lane. A load whose requested bytes are all covered by a buffered entry is answered from the buffer without touching the cache.

A locked (atomic) access bypasses the buffer. It is issued only once every older buffered store has reached the cache, so no buffered write can land between the parts of a locked sequence. A locked store uses the write port with a lock flag raised. A locked load uses the read port with a lock flag raised.

The core is stalled through `req_ready` whenever a request cannot be taken in the current cycle. Load data is returned one cycle after acceptance. Only the requested byte lanes are returned; the other lanes read as zero.

Top module: `dstore_port`

## Requirements
- R1: After reset the buffer is empty, and `wr_req`, `rd_req` and `rsp_valid` are all low while no request is presented.
- R2: An unlocked store (`req_write`=1, `req_lock`=0) to a word with no buffered entry takes a free entry in the same cycle. While all DEPTH entries are occupied, such a store is held (`req_ready`=0).
- R3: An unlocked store to a word that already has a buffered entry is accepted even when the buffer is full. It overwrites only the byte lanes set in `req_be` (lane b is bits 8b+7..8b), ORs its lanes into the entry mask, and takes no new entry.
- R4: While the buffer holds any entry, `wr_req` is high with `wr_lock`=0 and presents the oldest entry's word address, data and lane mask. Each cycle with `wr_ack` retires that entry. Entries leave in the order they were first allocated.
- R5: A load (`req_write`=0, `req_lock`=0) whose `req_be` lanes are all set in the matching entry's mask is accepted in the same cycle, with `rd_req` low. The buffered bytes are returned.
- R6: A load that matches a buffered entry which lacks any requested lane is held (`req_ready`=0), with `rd_req` low, until that entry has drained.
- R7: A load to a word with no buffered entry raises `rd_req` with `rd_lock`=0. It is accepted in the cycle `rd_ack` is high, and the cache word on `rd_data` is returned.
- R8: A locked request is held while the buffer is non-empty. Once the buffer is empty, a locked store raises `wr_req` with `wr_lock`=1 and is accepted with `wr_ack`. A locked load raises `rd_req` with `rd_lock`=1 and is accepted with `rd_ack`.
- R9: `rsp_valid` is high exactly one cycle after each accepted load. `rsp_rdata` carries the up-to-date word with the unrequested byte lanes forced to zero.
- R10: An unlocked store that matches the oldest entry in the same cycle that entry is retired by `wr_ack` is held for that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Core request present |
| req_write | input | 1 | 1 = store, 0 = load |
| req_lock | input | 1 | Locked (atomic) access |
| req_addr | input | AW | Word address |
| req_wdata | input | DW | Store data |
| req_be | input | DW/8 | Byte-lane mask (store lanes or requested load lanes) |
| req_ready | output | 1 | Request accepted this cycle |
| rsp_valid | output | 1 | Load data valid |
| rsp_rdata | output | DW | Load data, unrequested lanes zero |
| rd_req | output | 1 | Cache read request |
| rd_lock | output | 1 | Cache read is locked |
| rd_addr | output | AW | Cache read word address |
| rd_ack | input | 1 | Cache read granted, data valid this cycle |
| rd_data | input | DW | Cache read data |
| wr_req | output | 1 | Cache write request |
| wr_lock | output | 1 | Cache write is locked |
| wr_addr | output | AW | Cache write word address |
| wr_data | output | DW | Cache write data |
| wr_be | output | DW/8 | Cache write lane mask |
| wr_ack | input | 1 | Cache write granted this cycle |

## Verification
The assertions assume that the core request lines and the two cache grant inputs carry known values in every cycle after reset. They also assume that a grant has an effect only in a cycle where the matching request is raised. The grants are taken as independent of each other and of the request, so a drain and a store may meet on the same entry in one cycle. The stimulus changes inputs only at the falling clock edge and keeps addresses within eight words, so hits, merges and partial cover occur often. The grant bits are drawn at random in every cycle, which also produces the same-cycle collisions that the retire-versus-merge rule guards.

// File: rtl/dsp_pkg.sv
// Shared types for the store-coalescing data port.
// Assumes one core request per cycle, with its fields described by three flags.
package dsp_pkg;

    typedef enum logic [1:0] {
        KIND_NONE   = 2'd0,
        KIND_LOAD   = 2'd1,
        KIND_STORE  = 2'd2,
        KIND_LOCKED = 2'd3
    } req_kind_e;

    // Classify the core request into one of the four handling paths.
    function automatic req_kind_e classify(input logic valid, input logic lock);
        if (!valid)
            return KIND_NONE;
        else if (lock)
            return KIND_LOCKED;
        else
            return KIND_LOAD;
    endfunction

endpackage

// File: rtl/dsp_sbuf_store.sv
// Store buffer storage: a ring of DEPTH word entries, each with address, data
// and byte-lane mask. New entries enter at the tail and retire at the head.
// A merge updates one selected entry in place.
// Assumes: alloc only when not full, pop only when not empty, merge never
// aimed at the entry being popped in the same cycle.
module dsp_sbuf_store #(
    parameter int DEPTH = 4,
    parameter int AW    = 16,
    parameter int DW    = 32,
    localparam int BW   = DW / 8,
    localparam int IW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         alloc,
    input  logic                         merge,
    input  logic [IW-1:0]                merge_idx,
    input  logic [AW-1:0]                in_addr,
    input  logic [DW-1:0]                in_data,
    input  logic [BW-1:0]                in_be,
    input  logic                         pop,
    output logic [DEPTH-1:0]             slot_vld,
    output logic [DEPTH-1:0][AW-1:0]     slot_addr,
    output logic [DEPTH-1:0][DW-1:0]     slot_data,
    output logic [DEPTH-1:0][BW-1:0]     slot_be,
    output logic [IW-1:0]                head_idx,
    output logic                         full,
    output logic                         empty
);

    localparam logic [IW-1:0] LAST = IW'(DEPTH - 1);
    localparam logic [CW-1:0] CAP  = CW'(DEPTH);

    logic [IW-1:0] head_q, tail_q;
    logic [CW-1:0] count_q;

    assign head_idx = head_q;
    assign full     = (count_q == CAP);
    assign empty    = (count_q == '0);

    // Advance the ring pointers on allocation and retirement.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            head_q <= '0;
            tail_q <= '0;
        end else begin
            if (alloc) tail_q <= (tail_q == LAST) ? '0 : tail_q + 1'b1;
            if (pop)   head_q <= (head_q == LAST) ? '0 : head_q + 1'b1;
        end
    end

    // Track occupancy from simultaneous allocate and retire.
    always_ff @(posedge clk) begin
        if (!rst_n)
            count_q <= '0;
        else if (alloc && !pop)
            count_q <= count_q + 1'b1;
        else if (pop && !alloc)
            count_q <= count_q - 1'b1;
    end

    for (genvar s = 0; s < DEPTH; s++) begin : g_slot
        logic          vld_q;
        logic [AW-1:0] addr_q;
        logic [DW-1:0] data_q;
        logic [BW-1:0] be_q;
        logic [DW-1:0] merged;
        logic          take_new, take_mrg, retire;

        assign take_new = alloc && (tail_q == IW'(s));
        assign take_mrg = merge && (merge_idx == IW'(s));
        assign retire   = pop && (head_q == IW'(s));

        // Overlay the incoming lanes onto the held word.
        always_comb begin
            merged = data_q;
            for (int b = 0; b < BW; b++)
                if (in_be[b]) merged[8*b +: 8] = in_data[8*b +: 8];
        end

        // Load, merge or free this entry.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                vld_q  <= 1'b0;
                addr_q <= '0;
                data_q <= '0;
                be_q   <= '0;
            end else if (take_new) begin
                vld_q  <= 1'b1;
                addr_q <= in_addr;
                data_q <= in_data;
                be_q   <= in_be;
            end else if (take_mrg) begin
                data_q <= merged;
                be_q   <= be_q | in_be;
            end else if (retire) begin
                vld_q  <= 1'b0;
            end
        end

        assign slot_vld[s]  = vld_q;
        assign slot_addr[s] = addr_q;
        assign slot_data[s] = data_q;
        assign slot_be[s]   = be_q;
    end

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        alloc |-> !full);                                   // R2
    AST_ALLOC_FREE_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
        alloc |-> !slot_vld[tail_q]);                       // R2
    AST_POP_NONEMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> slot_vld[head_q]);                          // R4

endmodule

// File: rtl/dsp_fwd_lookup.sv
// Address match across all buffered entries. Reports whether the queried word
// is held, which entry holds it, whether the queried lanes are all covered,
// and the covered bytes with the unrequested lanes zeroed.
// Assumes at most one valid entry per word; the store path keeps that true.
module dsp_fwd_lookup #(
    parameter int DEPTH = 4,
    parameter int AW    = 16,
    parameter int DW    = 32,
    localparam int BW   = DW / 8,
    localparam int IW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [DEPTH-1:0]         slot_vld,
    input  logic [DEPTH-1:0][AW-1:0] slot_addr,
    input  logic [DEPTH-1:0][DW-1:0] slot_data,
    input  logic [DEPTH-1:0][BW-1:0] slot_be,
    input  logic [AW-1:0]            q_addr,
    input  logic [BW-1:0]            q_be,
    output logic                     hit,
    output logic [IW-1:0]            hit_idx,
    output logic                     covered,
    output logic [DW-1:0]            fwd_data
);

    logic [DEPTH-1:0] match;
    logic [BW-1:0]    sel_be;
    logic [DW-1:0]    sel_data;

    for (genvar s = 0; s < DEPTH; s++) begin : g_cmp
        assign match[s] = slot_vld[s] && (slot_addr[s] == q_addr);
    end

    // Encode the matching entry position.
    always_comb begin
        hit_idx = '0;
        for (int s = 0; s < DEPTH; s++)
            if (match[s]) hit_idx = IW'(s);
    end

    assign hit      = |match;
    assign sel_be   = slot_be[hit_idx];
    assign sel_data = slot_data[hit_idx];
    assign covered  = hit && ((sel_be & q_be) == q_be);

    // Keep only the requested lanes of the selected entry.
    always_comb begin
        fwd_data = '0;
        for (int b = 0; b < BW; b++)
            if (q_be[b]) fwd_data[8*b +: 8] = sel_data[8*b +: 8];
    end

    AST_UNIQUE_WORD: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(match));                                   // R3

endmodule

// File: rtl/dstore_port.sv
// Per-core data access port. Unlocked stores are buffered and coalesced per
// word; loads are served from the buffer when fully covered, held when only
// partly covered, and otherwise read from the cache. Locked accesses wait for
// an empty buffer and then go straight to the cache with a lock flag.
// Assumes one request per cycle on the core side; both cache grants may arrive
// in any cycle and are honoured only while the matching request is raised.
module dstore_port #(
    parameter int DEPTH = 4,
    parameter int AW    = 16,
    parameter int DW    = 32,
    localparam int BW   = DW / 8,
    localparam int IW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    input  logic          req_write,
    input  logic          req_lock,
    input  logic [AW-1:0] req_addr,
    input  logic [DW-1:0] req_wdata,
    input  logic [BW-1:0] req_be,
    output logic          req_ready,
    output logic          rsp_valid,
    output logic [DW-1:0] rsp_rdata,
    output logic          rd_req,
    output logic          rd_lock,
    output logic [AW-1:0] rd_addr,
    input  logic          rd_ack,
    input  logic [DW-1:0] rd_data,
    output logic          wr_req,
    output logic          wr_lock,
    output logic [AW-1:0] wr_addr,
    output logic [DW-1:0] wr_data,
    output logic [BW-1:0] wr_be,
    input  logic          wr_ack
);
    import dsp_pkg::*;

    logic [DEPTH-1:0]         slot_vld;
    logic [DEPTH-1:0][AW-1:0] slot_addr;
    logic [DEPTH-1:0][DW-1:0] slot_data;
    logic [DEPTH-1:0][BW-1:0] slot_be;
    logic [IW-1:0]            head_idx, hit_idx;
    logic                     full, empty, hit, covered;
    logic [DW-1:0]            fwd_data, lane_mask;

    req_kind_e kind;
    logic is_load, is_store, is_lk;
    logic pop, head_pop_hit, st_merge, st_alloc;
    logic ld_fwd, ld_cache, lk_go, ld_acc;

    // Decode the request path; a store is a non-locked write.
    always_comb begin
        kind = classify(req_valid, req_lock);
        if (kind == KIND_LOAD && req_write) kind = KIND_STORE;
    end

    assign is_load  = (kind == KIND_LOAD);
    assign is_store = (kind == KIND_STORE);
    assign is_lk    = (kind == KIND_LOCKED);

    dsp_sbuf_store #(.DEPTH(DEPTH), .AW(AW), .DW(DW)) store_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .alloc     (st_alloc),
        .merge     (st_merge),
        .merge_idx (hit_idx),
        .in_addr   (req_addr),
        .in_data   (req_wdata),
        .in_be     (req_be),
        .pop       (pop),
        .slot_vld  (slot_vld),
        .slot_addr (slot_addr),
        .slot_data (slot_data),
        .slot_be   (slot_be),
        .head_idx  (head_idx),
        .full      (full),
        .empty     (empty)
    );

    dsp_fwd_lookup #(.DEPTH(DEPTH), .AW(AW), .DW(DW)) lookup_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .slot_vld  (slot_vld),
        .slot_addr (slot_addr),
        .slot_data (slot_data),
        .slot_be   (slot_be),
        .q_addr    (req_addr),
        .q_be      (req_be),
        .hit       (hit),
        .hit_idx   (hit_idx),
        .covered   (covered),
        .fwd_data  (fwd_data)
    );

    // Drain and store-path decisions.
    assign pop          = !empty && wr_ack;
    assign head_pop_hit = pop && hit && (hit_idx == head_idx);
    assign st_merge     = is_store && hit && !head_pop_hit;
    assign st_alloc     = is_store && !hit && !full;

    // Load and locked-path decisions.
    assign ld_fwd   = is_load && covered;
    assign ld_cache = is_load && !hit;
    assign lk_go    = is_lk && empty;
    assign ld_acc   = ld_fwd || (ld_cache && rd_ack) || (lk_go && !req_write && rd_ack);

    assign req_ready = st_merge || st_alloc || ld_acc || (lk_go && req_write && wr_ack);

    // Cache read port.
    assign rd_req  = ld_cache || (lk_go && !req_write);
    assign rd_lock = is_lk;
    assign rd_addr = req_addr;

    // Cache write port: oldest entry, or a locked store once empty.
    always_comb begin
        if (!empty) begin
            wr_req  = 1'b1;
            wr_lock = 1'b0;
            wr_addr = slot_addr[head_idx];
            wr_data = slot_data[head_idx];
            wr_be   = slot_be[head_idx];
        end else begin
            wr_req  = lk_go && req_write;
            wr_lock = 1'b1;
            wr_addr = req_addr;
            wr_data = req_wdata;
            wr_be   = req_be;
        end
    end

    for (genvar b = 0; b < BW; b++) begin : g_mask
        assign lane_mask[8*b +: 8] = {8{req_be[b]}};
    end

    // Register the load answer from buffer or cache.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_rdata <= '0;
        end else begin
            rsp_valid <= ld_acc;
            if (ld_acc) rsp_rdata <= ld_fwd ? fwd_data : (rd_data & lane_mask);
        end
    end

    AST_DRAIN_WHEN_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !empty |-> (wr_req && !wr_lock));                   // R4
    AST_STALL_WHEN_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        (is_store && !hit && full) |-> !req_ready);         // R2
    AST_NO_READ_ON_HIT: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_write && !req_lock && hit) |-> !rd_req);  // R5
    AST_LOCK_NEEDS_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_lock && req_ready) |-> empty);    // R8
    AST_RETIRE_BEATS_MERGE: assert property (@(posedge clk) disable iff (!rst_n)
        (is_store && head_pop_hit) |-> !req_ready);         // R10
    AST_RSP_FOLLOWS_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_write && req_ready) |=> rsp_valid);  // R9

endmodule

// File: tb/dstore_port_tb.sv
// Cycle-by-cycle bench: a queue model of the buffer, a flat reference memory
// and a bench-side cache memory predict every output each clock.
module dstore_port_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 0, req_write = 0, req_lock = 0;
    logic [15:0] req_addr = '0;
    logic [31:0] req_wdata = '0;
    logic [3:0]  req_be = '0;
    logic        req_ready, rsp_valid;
    logic [31:0] rsp_rdata;
    logic        rd_req, rd_lock, rd_ack = 0;
    logic [15:0] rd_addr;
    logic [31:0] rd_data = '0;
    logic        wr_req, wr_lock, wr_ack = 0;
    logic [15:0] wr_addr;
    logic [31:0] wr_data;
    logic [3:0]  wr_be;

    always #2 clk = ~clk;

    dstore_port #(.DEPTH(4), .AW(16), .DW(32)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_write(req_write), .req_lock(req_lock),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_be(req_be),
        .req_ready(req_ready), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
        .rd_req(rd_req), .rd_lock(rd_lock), .rd_addr(rd_addr), .rd_ack(rd_ack),
        .rd_data(rd_data),
        .wr_req(wr_req), .wr_lock(wr_lock), .wr_addr(wr_addr), .wr_data(wr_data),
        .wr_be(wr_be), .wr_ack(wr_ack)
    );

    int nvec = 0, nfail = 0;
    bit done = 0;
    logic [15:0] q_a[$];
    logic [31:0] q_d[$];
    logic [3:0]  q_b[$];
    logic [31:0] ref_mem[8];
    logic [31:0] cache_mem[8];
    bit          exp_rv = 0;
    logic [31:0] exp_rd = '0;

    task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
        nvec++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    function automatic logic [31:0] lanes(input logic [3:0] be);
        logic [31:0] m = '0;
        for (int b = 0; b < 4; b++) if (be[b]) m[8*b +: 8] = 8'hff;
        return m;
    endfunction

    function automatic logic [31:0] overlay(input logic [31:0] old, input logic [31:0] nw, input logic [3:0] be);
        return (old & ~lanes(be)) | (nw & lanes(be));
    endfunction

    function automatic int find(input logic [15:0] a);
        for (int i = 0; i < q_a.size(); i++) if (q_a[i] == a) return i;
        return -1;
    endfunction

    task automatic cycle(input bit v, input bit w, input bit l, input logic [15:0] a,
                         input logic [31:0] d, input logic [3:0] be, input bit rack, input bit wack);
        int sz, idx;
        bit popping, exp_wr, exp_rdy, exp_rdq, new_rv;
        string tag;
        @(negedge clk);
        chk("R9", "rsp_valid", rsp_valid, exp_rv);
        if (exp_rv) chk("R9", "rsp_rdata", rsp_rdata, exp_rd);
        req_valid = v; req_write = w; req_lock = l; req_addr = a;
        req_wdata = d; req_be = be; rd_ack = rack; wr_ack = wack;
        rd_data = cache_mem[a[2:0]];
        #1;
        sz = q_a.size();
        idx = find(a);
        popping = (sz > 0) && wack;
        exp_wr = (sz > 0) || (v && l && w);
        chk("R4", "wr_req", wr_req, exp_wr);
        if (sz > 0) begin
            chk("R4", "wr_addr", wr_addr, q_a[0]);
            chk("R4", "wr_data", wr_data, q_d[0]);
            chk("R4", "wr_be", wr_be, q_b[0]);
            chk("R4", "wr_lock", wr_lock, 0);
        end else if (exp_wr) begin
            chk("R8", "wr_lock", wr_lock, 1);
            chk("R8", "wr_addr", wr_addr, a);
            chk("R8", "wr_data", wr_data, d);
        end
        exp_rdy = 0; exp_rdq = 0; tag = "R7";
        if (v && l) begin
            tag = "R8";
            exp_rdq = (sz == 0) && !w;
            exp_rdy = (sz == 0) && (w ? wack : rack);
        end else if (v && w) begin
            if (idx == 0 && popping) begin tag = "R10"; exp_rdy = 0; end
            else if (idx >= 0) begin tag = "R3"; exp_rdy = 1; end
            else begin tag = "R2"; exp_rdy = (sz < 4); end
        end else if (v) begin
            if (idx >= 0 && ((q_b[idx] & be) == be)) begin tag = "R5"; exp_rdy = 1; end
            else if (idx >= 0) begin tag = "R6"; exp_rdy = 0; end
            else begin tag = "R7"; exp_rdq = 1; exp_rdy = rack; end
        end
        if (v) chk(tag, "req_ready", req_ready, exp_rdy);
        chk(tag, "rd_req", rd_req, exp_rdq);
        if (exp_rdq) chk(tag, "rd_lock", rd_lock, l);
        // advance the model to the state after this clock edge
        if (popping) begin
            cache_mem[q_a[0][2:0]] = overlay(cache_mem[q_a[0][2:0]], q_d[0], q_b[0]);
            void'(q_a.pop_front()); void'(q_d.pop_front()); void'(q_b.pop_front());
        end else if (exp_wr && wack) begin
            cache_mem[a[2:0]] = overlay(cache_mem[a[2:0]], d, be);
        end
        new_rv = 0;
        if (v && exp_rdy) begin
            if (w) begin
                ref_mem[a[2:0]] = overlay(ref_mem[a[2:0]], d, be);
                if (!l) begin
                    idx = find(a);
                    if (idx >= 0) begin
                        q_d[idx] = overlay(q_d[idx], d, be);
                        q_b[idx] = q_b[idx] | be;
                    end else begin
                        q_a.push_back(a); q_d.push_back(d); q_b.push_back(be);
                    end
                end
            end else begin
                new_rv = 1;
                exp_rd = ref_mem[a[2:0]] & lanes(be);
            end
        end
        exp_rv = new_rv;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
            $finish;
        end
    endtask

    initial begin
        #400000;
        nfail++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        for (int i = 0; i < 8; i++) begin ref_mem[i] = '0; cache_mem[i] = '0; end
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        chk("R1", "wr_req", wr_req, 0);
        chk("R1", "rd_req", rd_req, 0);
        chk("R1", "rsp_valid", rsp_valid, 0);
        chk("R1", "req_ready", req_ready, 0);
        // fill the buffer with half-word stores, no drain grant
        for (int i = 0; i < 4; i++)
            cycle(1, 1, 0, 16'(i), 32'h1111_0000 * 32'(i + 1) + 32'h0000_a5a5, 4'b0011, 0, 0);
        cycle(1, 1, 0, 16'd4, 32'hdead_beef, 4'hf, 0, 0);        // R2 full stall
        cycle(1, 1, 0, 16'd1, 32'h0000_7700, 4'b0010, 0, 0);     // R3 merge while full
        cycle(1, 0, 0, 16'd0, 32'h0, 4'b1100, 1, 0);             // R6 partial cover
        cycle(1, 0, 0, 16'd1, 32'h0, 4'b0011, 1, 0);             // R5 forward
        cycle(1, 0, 1, 16'd2, 32'h0, 4'hf, 1, 0);                // R8 locked waits
        cycle(1, 0, 0, 16'd6, 32'h0, 4'b1001, 0, 0);             // R7 miss, no grant
        cycle(1, 0, 0, 16'd6, 32'h0, 4'b1001, 1, 0);             // R7 miss granted
        cycle(1, 1, 0, 16'd0, 32'h5555_5555, 4'b1000, 0, 1);     // R10 head retiring
        for (int i = 0; i < 5; i++) cycle(0, 0, 0, 16'd0, 32'h0, 4'h0, 0, 1);  // R4 drain
        cycle(1, 1, 1, 16'd3, 32'hcafe_f00d, 4'hf, 0, 1);        // R8 locked store
        cycle(1, 0, 1, 16'd3, 32'h0, 4'hf, 1, 0);                // R8 locked load
        cycle(1, 0, 0, 16'd0, 32'h0, 4'hf, 1, 0);                // R7 after drain
        for (int n = 0; n < 4000; n++) begin
            bit v  = ($urandom % 10) < 8;
            bit w  = ($urandom % 2) == 1;
            bit l  = ($urandom % 25) == 0;
            logic [15:0] a  = 16'($urandom % 8);
            logic [31:0] d  = $urandom;
            logic [3:0]  be = 4'($urandom);
            if (be == 4'h0) be = 4'hf;
            cycle(v, w, l, a, d, be, ($urandom % 3) != 0, ($urandom % 3) == 0);
        end
        cycle(0, 0, 0, 16'd0, 32'h0, 4'h0, 0, 0);
        finish_run();
    end

endmodule